// File: doc/BRIEF.md
# Inter-Processor Mailbox Register Bank

This block is a small bank of registers that two processors share, seen from the I/O processor's side. The local processor reaches it through a synchronous port that reads and writes in 16-bit or 32-bit sizes. A second, simpler port lets the peer processor load its own mailbox and set or clear bits in the two flag words. Only address bit 11 and address bits 7:4 choose a register. All other address bits are ignored, so every register shows up at several aliased addresses inside the window.

Each slot has its own write rule:
- The peer mailbox is read-only from this side.
- The local mailbox is plain storage.
- One flag word clears the bits that are written as ones. The other sets them.
- The control word forces a fixed code into its top nibble and flips a group of bits.
- One slot always reads as zero.
- Every other slot is plain storage.

Read data is registered and appears one cycle after the read strobe.

Top module: `mbox_regbank`

## Requirements
- R1: The register is chosen by the key {addr[11], addr[7:4]}, and the other address bits have no effect. rdata takes the selected value on the clock edge where rd_en is 1. It keeps that value while rd_en is 0.
- R2: Key 0x00 holds the peer mailbox. A local write there changes nothing. peer_mbox_we loads all 32 bits from peer_mbox_wdata.
- R3: Key 0x01 (offset 0x10) holds the local mailbox. A write stores the written value and a read returns it.
- R4: A local write to offset 0x20 clears each bit of the clear-flag word that is 1 in the written data.
- R5: A local write to offset 0x30 sets each bit of the set-flag word that is 1 in the written data.
- R6: A write to the control word (offset 0x40) with data bit 5 or bit 7 at 1 makes control bits 15:12 equal 0x2.
- R7: After that step, data bits 7:4 act as a toggle group. If any of them is already 1 in the control word, all of them are cleared. Otherwise all of them are set. No other control bit changes.
- R8: A 32-bit read of the control word returns its value ORed with 0xF0000002. A 16-bit read returns its low half ORed with 0x0002.
- R9: Offset 0x60 always reads as zero, and writes to it have no visible effect.
- R10: Every other key, including keys with addr[11]=1, is plain read/write storage.
- R11: When acc32 is 0 the access is 16 bits wide. A write uses only wdata[15:0] and changes only bits 15:0 of the target. A read returns bits 15:0 zero-extended.
- R12: The peer's set and clear masks act on both flag words every cycle. When they land in the same cycle as a local write to the same flag word, the masks are merged bitwise and set wins over clear.
- R13: Synchronous active-high reset sets every register, the storage and rdata to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Local read strobe |
| wr_en | input | 1 | Local write strobe |
| acc32 | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| addr | input | ADDR_W | Local address inside the window |
| wdata | input | 32 | Local write data |
| rdata | output | 32 | Registered read data |
| peer_mbox_we | input | 1 | Peer loads its mailbox |
| peer_mbox_wdata | input | 32 | Peer mailbox data |
| peer_set0 | input | 32 | Peer set mask, clear-flag word |
| peer_clr0 | input | 32 | Peer clear mask, clear-flag word |
| peer_set1 | input | 32 | Peer set mask, set-flag word |
| peer_clr1 | input | 32 | Peer clear mask, set-flag word |

## Verification
The bench uses the default ADDR_W of 12. That gives a key space of only 32 slots, so every key can be written and read back at both access sizes, through addresses whose ignored bits are filled with noise. The control word is swept over all sixteen values of its toggle group at both sizes. This covers every code-forcing and toggle transition from the states that earlier writes leave behind. The flag words are driven with peer masks that overlap local writes in the same cycle, which exercises the set-wins merge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 5;

  typedef enum logic [2:0] {
    K_PEER, K_LOCAL, K_CLR, K_SET, K_CTRL, K_ZERO, K_STORE
  } kind_e;

  localparam logic [DATA_W-1:0] CTRL_OR32 = 32'hF000_0002;
  localparam logic [DATA_W-1:0] CTRL_OR16 = 32'h0000_0002;
  localparam logic [3:0]        CTRL_CODE = 4'h2;

  function automatic kind_e kind_of(input logic [KEY_W-1:0] key);
    case (key)
      5'h00:   return K_PEER;
      5'h01:   return K_LOCAL;
      5'h02:   return K_CLR;
      5'h03:   return K_SET;
      5'h04:   return K_CTRL;
      5'h06:   return K_ZERO;
      default: return K_STORE;
    endcase
  endfunction
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [KEY_W-1:0]  key,
  output kind_e             kind
);
  localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'('h8F0);

  logic unused_addr_bits;
  assign unused_addr_bits = ^(addr & ~SEL_MASK);

  assign key  = {addr[11], addr[7:4]};
  assign kind = kind_of(key);
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic [DATA_W-1:0] set_mask,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [3:0]        tog,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (tog[1] | tog[3]) nxt[15:12] = CTRL_CODE;
    if ((nxt[7:4] & tog) != 4'h0) nxt[7:4] = nxt[7:4] & ~tog;
    else                          nxt[7:4] = nxt[7:4] | tog;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= nxt;
  end
endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter int SKEY_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [SKEY_W-1:0] key,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << SKEY_W;
  localparam int HALF  = DATA_W / 2;

  logic [HALF-1:0] mem_lo [DEPTH];
  logic [HALF-1:0] mem_hi [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_lo[i] <= '0;
        mem_hi[i] <= '0;
      end
    end else begin
      if (we_lo) mem_lo[key] <= wdata[HALF-1:0];
      if (we_hi) mem_hi[key] <= wdata[DATA_W-1:HALF];
    end
  end

  assign rdata = {mem_hi[key], mem_lo[key]};
endmodule

// File: rtl/mbox_regbank.sv
module mbox_regbank
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              acc32,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              peer_mbox_we,
  input  logic [31:0]       peer_mbox_wdata,
  input  logic [31:0]       peer_set0,
  input  logic [31:0]       peer_clr0,
  input  logic [31:0]       peer_set1,
  input  logic [31:0]       peer_clr1
);
  localparam int HALF = DATA_W / 2;

  logic [KEY_W-1:0]  key;
  kind_e             kind;
  logic [DATA_W-1:0] wmask, wd_m;
  logic [DATA_W-1:0] peer_mbox_q, local_mbox_q, flag0_q, flag1_q, ctrl_q, store_rd;
  logic [DATA_W-1:0] loc_clr, loc_set, rd_val;

  mbox_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .key  (key),
    .kind (kind)
  );

  assign wmask = acc32 ? '1 : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign wd_m  = wdata & wmask;

  always_ff @(posedge clk) begin
    if (rst)               peer_mbox_q <= '0;
    else if (peer_mbox_we) peer_mbox_q <= peer_mbox_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                           local_mbox_q <= '0;
    else if (wr_en && kind == K_LOCAL) local_mbox_q <= (local_mbox_q & ~wmask) | wd_m;
  end

  assign loc_clr = (wr_en && kind == K_CLR) ? wd_m : '0;
  assign loc_set = (wr_en && kind == K_SET) ? wd_m : '0;

  mbox_flags u_flag_clr (
    .clk      (clk),
    .rst      (rst),
    .clr_mask (peer_clr0 | loc_clr),
    .set_mask (peer_set0),
    .q        (flag0_q)
  );

  mbox_flags u_flag_set (
    .clk      (clk),
    .rst      (rst),
    .clr_mask (peer_clr1),
    .set_mask (peer_set1 | loc_set),
    .q        (flag1_q)
  );

  mbox_ctrl u_ctrl (
    .clk (clk),
    .rst (rst),
    .we  (wr_en && kind == K_CTRL),
    .tog (wd_m[7:4]),
    .q   (ctrl_q)
  );

  mbox_store #(.SKEY_W(KEY_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we_lo (wr_en && kind == K_STORE),
    .we_hi (wr_en && kind == K_STORE && acc32),
    .key   (key),
    .wdata (wdata),
    .rdata (store_rd)
  );

  always_comb begin
    case (kind)
      K_PEER:  rd_val = peer_mbox_q;
      K_LOCAL: rd_val = local_mbox_q;
      K_CLR:   rd_val = flag0_q;
      K_SET:   rd_val = flag1_q;
      K_CTRL:  rd_val = ctrl_q | (acc32 ? CTRL_OR32 : CTRL_OR16);
      K_ZERO:  rd_val = '0;
      default: rd_val = store_rd;
    endcase
    rd_val = rd_val & wmask;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/mbox_regbank_chk.sv
module mbox_regbank_chk (
  input logic        clk,
  input logic        rst,
  input logic        rd_en,
  input logic        wr_en,
  input logic        acc32,
  input logic [4:0]  key,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        peer_mbox_we,
  input logic [31:0] peer_mbox_q,
  input logic [31:0] peer_set0,
  input logic [31:0] flag0_q,
  input logic [31:0] ctrl_q
);
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  a_r2_peer_hold: assert property (@(posedge clk) disable iff (rst)
    !peer_mbox_we |=> $stable(peer_mbox_q));

  a_r6_ctrl_code: assert property (@(posedge clk) disable iff (rst)
    (wr_en && key == 5'h04 && (wdata[5] || wdata[7])) |=> ctrl_q[15:12] == 4'h2);

  a_r7_ctrl_set_group: assert property (@(posedge clk) disable iff (rst)
    (wr_en && key == 5'h04 && wdata[7:4] != 4'h0 && (ctrl_q[7:4] & wdata[7:4]) == 4'h0)
      |=> (ctrl_q[7:4] & $past(wdata[7:4])) == $past(wdata[7:4]));

  a_r8_ctrl_read32: assert property (@(posedge clk) disable iff (rst)
    (rd_en && acc32 && key == 5'h04) |=> (rdata[31:28] == 4'hF && rdata[1]));

  a_r9_zero_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && key == 5'h06) |=> rdata == 32'h0);

  a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
    (peer_set0 != 32'h0) |=> (flag0_q & $past(peer_set0)) == $past(peer_set0));
endmodule

bind mbox_regbank mbox_regbank_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .acc32        (acc32),
  .key          (key),
  .wdata        (wdata),
  .rdata        (rdata),
  .peer_mbox_we (peer_mbox_we),
  .peer_mbox_q  (peer_mbox_q),
  .peer_set0    (peer_set0),
  .flag0_q      (flag0_q),
  .ctrl_q       (ctrl_q)
);

// File: tb/mbox_regbank_bench.sv
module mbox_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0, acc32 = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        peer_mbox_we = 1'b0;
  logic [31:0] peer_mbox_wdata = '0;
  logic [31:0] peer_set0 = '0, peer_clr0 = '0, peer_set1 = '0, peer_clr1 = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_store [32];
  logic [31:0] m_peer, m_local, m_f0, m_f1, m_ctrl;

  always #10 clk = ~clk;

  mbox_regbank #(.ADDR_W(12)) u_mbox_regbank (
    .clk, .rst, .rd_en, .wr_en, .acc32, .addr, .wdata, .rdata,
    .peer_mbox_we, .peer_mbox_wdata, .peer_set0, .peer_clr0, .peer_set1, .peer_clr1
  );

  function automatic logic [11:0] addr_of(input int k, input logic [11:0] noise);
    logic [4:0] kk = 5'(k);
    return {kk[4], 3'b000, kk[3:0], 4'h0} | (noise & 12'h70F);
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R7/R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int k, input bit w);
    logic [31:0] v;
    case (k)
      0: v = m_peer;
      1: v = m_local;
      2: v = m_f0;
      3: v = m_f1;
      4: v = w ? (m_ctrl | 32'hF000_0002) : (m_ctrl | 32'h2);
      6: v = 32'h0;
      default: v = m_store[k];
    endcase
    if (!w) v = {16'h0, v[15:0]};
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // One clock with an optional local write plus whatever peer inputs the caller set.
  task automatic cyc(input bit wr, input logic [11:0] a, input logic [31:0] d, input bit w);
    logic [4:0]  k  = {a[11], a[7:4]};
    logic [31:0] dm = w ? d : {16'h0, d[15:0]};
    logic [31:0] msk = w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] lclr = '0, lset = '0;
    logic [3:0]  t;
    wr_en = wr; addr = a; wdata = d; acc32 = w;
    if (wr) begin
      case (k)
        5'd0, 5'd6: ;
        5'd1: m_local = (m_local & ~msk) | dm;
        5'd2: lclr = dm;
        5'd3: lset = dm;
        5'd4: begin
          if (dm[5] || dm[7]) m_ctrl[15:12] = 4'h2;
          t = dm[7:4];
          if ((m_ctrl[7:4] & t) != 0) m_ctrl[7:4] = m_ctrl[7:4] & ~t;
          else                        m_ctrl[7:4] = m_ctrl[7:4] | t;
        end
        default: m_store[k] = (m_store[k] & ~msk) | dm;
      endcase
    end
    if (peer_mbox_we) m_peer = peer_mbox_wdata;
    m_f0 = (m_f0 & ~(peer_clr0 | lclr)) | peer_set0;
    m_f1 = (m_f1 & ~peer_clr1) | (peer_set1 | lset);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    peer_mbox_we = 1'b0; peer_set0 = '0; peer_clr0 = '0; peer_set1 = '0; peer_clr1 = '0;
  endtask

  task automatic rd(input logic [11:0] a, input bit w, input string tag);
    rd_en = 1'b1; addr = a; acc32 = w;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rdata, exp_rd({a[11], a[7:4]}, w));
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    for (int i = 0; i < 32; i++) m_store[i] = '0;
    m_peer = '0; m_local = '0; m_f0 = '0; m_f1 = '0; m_ctrl = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R13 rdata after reset", rdata, 32'h0);

    // R13: every slot reads zero after reset (control shows its fixed OR bits)
    for (int k = 0; k < 32; k++) begin
      rd(addr_of(k, 12'h000), 1'b1, "R13");
      rd(addr_of(k, 12'h000), 1'b0, "R13");
    end

    // R1/R10 and per-slot rules: write every key through noisy aliases, read back cleanly
    for (int k = 0; k < 32; k++)
      cyc(1'b1, addr_of(k, 12'(k * 37)), {8'hA0 + 8'(k), 8'h5A, 8'(k), 8'hC3}, 1'b1);
    for (int k = 0; k < 32; k++) begin
      rd(addr_of(k, 12'h000), 1'b1, tag_of(k));
      rd(addr_of(k, 12'h70F), 1'b1, "R1 alias");
    end

    // R11: 16-bit writes touch only the low half; 16-bit reads zero-extend
    for (int k = 0; k < 32; k++)
      cyc(1'b1, addr_of(k, 12'h105), {16'hDEAD, ~16'(k)}, 1'b0);
    for (int k = 0; k < 32; k++) begin
      rd(addr_of(k, 12'h000), 1'b1, "R11 wide after half write");
      rd(addr_of(k, 12'h000), 1'b0, "R11 half read");
    end

    // R1: rdata holds while rd_en is low
    rd(addr_of(1, 12'h0), 1'b1, "R3");
    held = rdata;
    cyc(1'b1, addr_of(1, 12'h0), 32'h0BAD_F00D, 1'b1);
    addr = addr_of(6, 12'h0);
    @(posedge clk); @(negedge clk);
    check("R1 hold", rdata, held);

    // R2: local write ignored, peer load takes effect
    cyc(1'b1, addr_of(0, 12'h0), 32'hFFFF_FFFF, 1'b1);
    rd(addr_of(0, 12'h0), 1'b1, "R2 local write ignored");
    peer_mbox_we = 1'b1; peer_mbox_wdata = 32'h1357_9BDF;
    cyc(1'b0, '0, '0, 1'b1);
    rd(addr_of(0, 12'h0), 1'b1, "R2 peer load");

    // R4/R12: clear-flag word
    peer_set0 = 32'hFFFF_FFFF;
    cyc(1'b0, '0, '0, 1'b1);
    rd(addr_of(2, 12'h0), 1'b1, "R12 peer set");
    cyc(1'b1, addr_of(2, 12'h0), 32'h0F0F_0F0F, 1'b1);
    rd(addr_of(2, 12'h0), 1'b1, "R4 clear 32");
    cyc(1'b1, addr_of(2, 12'h0), 32'hFFFF_00F0, 1'b0);
    rd(addr_of(2, 12'h0), 1'b1, "R4 clear 16");
    peer_set0 = 32'h0000_0F00;
    cyc(1'b1, addr_of(2, 12'h0), 32'h0000_FF00, 1'b1);
    rd(addr_of(2, 12'h0), 1'b1, "R12 set wins over local clear");
    check("R12 merged value", rdata, 32'hF0F0_0F00);
    peer_clr0 = 32'hF000_0000;
    cyc(1'b0, '0, '0, 1'b1);
    rd(addr_of(2, 12'h0), 1'b1, "R12 peer clear");

    // R5/R12: set-flag word
    cyc(1'b1, addr_of(3, 12'h0), 32'h1234_0000, 1'b1);
    rd(addr_of(3, 12'h0), 1'b1, "R5 set 32");
    cyc(1'b1, addr_of(3, 12'h0), 32'hFFFF_0081, 1'b0);
    rd(addr_of(3, 12'h0), 1'b1, "R5 set 16");
    peer_set1 = 32'h0000_0080; peer_clr1 = 32'h1000_0080;
    cyc(1'b0, '0, '0, 1'b1);
    rd(addr_of(3, 12'h0), 1'b1, "R12 set beats clear");

    // R6/R7/R8: control word sweep over the toggle group at both sizes
    for (int n = 0; n < 16; n++) begin
      for (int w = 0; w < 2; w++) begin
        cyc(1'b1, addr_of(4, 12'h20A), 32'hABCD_0A0A | (32'(n) << 4), w[0]);
        rd(addr_of(4, 12'h0), 1'b1, "R6/R7 wide");
        rd(addr_of(4, 12'h0), 1'b0, "R8 half");
      end
    end

    // R9: zero slot after all-ones write
    cyc(1'b1, addr_of(6, 12'h0), 32'hFFFF_FFFF, 1'b1);
    rd(addr_of(6, 12'h0), 1'b1, "R9");
    rd(addr_of(6, 12'h0), 1'b0, "R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end
endmodule